// File: doc/BRIEF.md
# Clock Routing Matrix with Per-Bank Post-Dividers

This block distributes clocks to five output banks. Four candidate sources reach it: the currently chosen input reference and three synthesized clocks. Each bank picks its own source through a 2-bit select field. Bank 1 carries its chosen source as it is. Banks 2 to 5 pass their source through a 10-bit post-divider. Each divider holds two stored divide values, and a per-bank bit picks the active one. A per-bank bypass bit skips the divider entirely. After that, every output has its own enable and its own inversion, so two banks can form the legs of a differential pair.

The block runs in one fast sampling clock domain. The source clocks are level inputs sampled on that clock. Each post-divider counts rising edges of its routed source. Every bank output, divided or not, comes from one register stage, so all banks show the same one-cycle latency. Configuration arrives as static register inputs. When all of them are zero except the bank 1 enable, only bank 1 toggles, and it carries the reference.

Top module: `clkmx_route_top`

## Requirements
- R1: A bank's select value 0 routes the reference clock, and values 1, 2 and 3 route synthesized clocks 1, 2 and 3.
- R2: Each bank's select field acts independently, so banks may carry different sources at the same time.
- R3: Bank 1 has no divider. With the output enabled and not inverted, it equals its routed source delayed by one sampling-clock cycle.
- R4: For a divided bank with active divide value N of at least 2, the output period is N source periods and its high time is floor(N/2) source periods. After reset, a period starts with its high phase on the first source rising edge.
- R5: An active divide value of 0 or 1 passes the routed source through undivided.
- R6: A set bypass bit passes the routed source through undivided, whatever the divide values are.
- R7: A pick bit of 0 makes divide value A active, and a pick bit of 1 makes divide value B active.
- R8: A change of the pick bit during a divider period takes effect only after that period completes. The current period keeps its full length.
- R9: A disabled output is low before inversion, so it reads 0 when not inverted and 1 when inverted, whatever its source is doing.
- R10: Each output's inversion bit acts on that output alone. Two banks routing the same undivided source with opposite inversion are always complementary.
- R11: While reset is asserted, all divider and routing state is cleared, so each output reads its inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Currently chosen input reference (select code 0) |
| synth_clk_i | input | 3 | Synthesized clocks; bit k is select code k+1 |
| route_sel_i | input | 10 | Per-bank source select, 2 bits per bank, bank 1 in bits 1:0 |
| div_a_i | input | 40 | Divide value A for banks 2 to 5, 10 bits each, bank 2 lowest |
| div_b_i | input | 40 | Divide value B for banks 2 to 5, 10 bits each, bank 2 lowest |
| div_pick_i | input | 4 | Per divided bank: 0 picks value A, 1 picks value B |
| div_bypass_i | input | 4 | Per divided bank: 1 bypasses the divider |
| out_inv_i | input | 5 | Per-bank output inversion, bank 1 in bit 0 |
| out_en_i | input | 5 | Per-bank output enable, bank 1 in bit 0 |
| bank_o | output | 5 | Bank outputs, bank 1 in bit 0 |

## Verification
The bench measures the period and high time of every bank in sampling-clock cycles. It covers each source, odd and even divide values, and the extremes 0, 1, 2 and 1023. A divider with an off-by-one count or the wrong high span would show a period or duty that is off by one source period. A pick change made just after a period starts must leave that period at the old length. A design that switches at once would produce a truncated pulse. Disabled outputs, opposite-inversion pairs and the reset level are watched over many cycles, and so is the one-cycle latency of bank 1. Here a faulty design would leak the source through a disabled output, or drift by a cycle.

// File: rtl/clkmx_pkg.sv
package clkmx_pkg;

  // Source select codes (2 bits per bank)
  typedef enum logic [1:0] {
    SRC_REF  = 2'd0,
    SRC_SYN1 = 2'd1,
    SRC_SYN2 = 2'd2,
    SRC_SYN3 = 2'd3
  } src_code_e;

  // Divider degenerates to a plain copy when bypassed or when N < 2
  function automatic logic pass_through(logic bypass, int unsigned div_n);
    return bypass || (div_n < 2);
  endfunction

  // Number of source periods the divided output stays high
  function automatic int unsigned high_span(int unsigned div_n);
    return div_n >> 1;
  endfunction

  // True when the edge at this phase closes the current output period
  function automatic logic period_end(int unsigned phase, int unsigned div_n);
    return (phase + 1) >= div_n;
  endfunction

endpackage

// File: rtl/clkmx_src_mux.sv
module clkmx_src_mux #(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NSRC-1:0]  srcs,
  input  logic [SEL_W-1:0] sel,
  output logic             routed
);
  always_comb begin
    routed = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SEL_W'(i)) routed = srcs[i];
    end
  end
endmodule

// File: rtl/clkmx_post_div.sv
module clkmx_post_div
  import clkmx_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic             pick,
  input  logic             bypass,
  output logic             q
);
  logic             src_d;
  logic             adv;        // rising edge of routed source seen this cycle
  logic             pass_mode;  // divider acts as a copy
  logic             wrap;       // this edge ends the output period
  logic             act_pick;   // divide value in force for the current period
  logic [DIV_W-1:0] div_n;
  logic [DIV_W-1:0] ph;

  assign div_n     = act_pick ? div_b : div_a;
  assign adv       = src & ~src_d;
  assign pass_mode = pass_through(bypass, 32'(div_n));
  assign wrap      = period_end(32'(ph), 32'(div_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d    <= 1'b0;
      q        <= 1'b0;
      ph       <= '0;
      act_pick <= 1'b0;
    end else begin
      src_d <= src;
      if (pass_mode) begin
        q  <= src;
        ph <= '0;
      end else if (adv) begin
        q  <= (32'(ph) < high_span(32'(div_n)));
        ph <= wrap ? '0 : ph + DIV_W'(1);
      end
      // the pick is only sampled between periods
      if (pass_mode || (ph == '0 && !adv)) act_pick <= pick;
    end
  end

  // R4: phase only moves on a source rising edge
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !pass_mode) |=> $stable(ph));

  // R4: each output period opens with its high phase
  p_period_start_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_mode && adv && ph == '0) |=> q);

  // R8: selection locked while a period is in progress
  p_pick_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_mode && (ph != '0 || adv)) |=> $stable(act_pick));

  // R5/R6: copy mode follows the source one cycle later
  p_pass_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_mode |=> (q == $past(src)));

endmodule

// File: rtl/clkmx_out_stage.sv
module clkmx_out_stage (
  input  logic core,
  input  logic en,
  input  logic inv,
  output logic pin
);
  always_comb begin
    pin = (core & en) ^ inv;
    // R9: disabled output rests at its inversion level
    p_dis_level_r9: assert (en || (pin == inv));
  end
endmodule

// File: rtl/clkmx_route_top.sv
module clkmx_route_top #(
  parameter int NUM_SYNTH = 3,
  parameter int NUM_BANKS = 5,
  parameter int DIV_W     = 10,
  localparam int NSRC     = NUM_SYNTH + 1,
  localparam int SEL_W    = $clog2(NSRC),
  localparam int NDIV     = NUM_BANKS - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_clk_i,
  input  logic [NUM_SYNTH-1:0]       synth_clk_i,
  input  logic [NUM_BANKS*SEL_W-1:0] route_sel_i,
  input  logic [NDIV*DIV_W-1:0]      div_a_i,
  input  logic [NDIV*DIV_W-1:0]      div_b_i,
  input  logic [NDIV-1:0]            div_pick_i,
  input  logic [NDIV-1:0]            div_bypass_i,
  input  logic [NUM_BANKS-1:0]       out_inv_i,
  input  logic [NUM_BANKS-1:0]       out_en_i,
  output logic [NUM_BANKS-1:0]       bank_o
);
  logic [NSRC-1:0]      srcs;
  logic [NUM_BANKS-1:0] routed;

  assign srcs = {synth_clk_i, ref_clk_i};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic lane_q;

    clkmx_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
      .srcs   (srcs),
      .sel    (route_sel_i[b*SEL_W +: SEL_W]),
      .routed (routed[b])
    );

    if (b == 0) begin : g_plain
      // R3: first bank has no divider, one register stage only
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= 1'b0;
        else        lane_q <= routed[b];
      end

      p_bank1_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (lane_q == $past(routed[b])));
    end else begin : g_div
      clkmx_post_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (routed[b]),
        .div_a  (div_a_i[(b-1)*DIV_W +: DIV_W]),
        .div_b  (div_b_i[(b-1)*DIV_W +: DIV_W]),
        .pick   (div_pick_i[b-1]),
        .bypass (div_bypass_i[b-1]),
        .q      (lane_q)
      );
    end

    clkmx_out_stage u_out (
      .core (lane_q),
      .en   (out_en_i[b]),
      .inv  (out_inv_i[b]),
      .pin  (bank_o[b])
    );
  end

endmodule

// File: tb/clkmx_route_top_test.sv
`timescale 1ns/1ps
module clkmx_route_top_test;
  typedef struct packed {
    logic [2:0] bank;
    logic [1:0] sel;
    logic [9:0] na;
    logic [9:0] nb;
    logic       pick;
    logic       byp;
  } vec_t;

  // bank index is 0-based (0 = bank 1)
  localparam vec_t VECS [0:10] = '{
    '{3'd0, 2'd0, 10'd0,    10'd0, 1'b0, 1'b0},
    '{3'd0, 2'd3, 10'd5,    10'd0, 1'b0, 1'b0},
    '{3'd1, 2'd1, 10'd3,    10'd0, 1'b0, 1'b0},
    '{3'd2, 2'd2, 10'd9,    10'd4, 1'b1, 1'b0},
    '{3'd3, 2'd0, 10'd5,    10'd0, 1'b0, 1'b0},
    '{3'd4, 2'd3, 10'd0,    10'd0, 1'b0, 1'b0},
    '{3'd4, 2'd1, 10'd1,    10'd7, 1'b0, 1'b0},
    '{3'd1, 2'd2, 10'd7,    10'd7, 1'b0, 1'b1},
    '{3'd2, 2'd0, 10'd1023, 10'd0, 1'b0, 1'b0},
    '{3'd3, 2'd1, 10'd2,    10'd9, 1'b0, 1'b0},
    '{3'd4, 2'd0, 10'd2,    10'd6, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [2:0]  syn = '0;
  logic [9:0]  route_sel = '0;
  logic [39:0] div_a = '0;
  logic [39:0] div_b = '0;
  logic [3:0]  div_pick = '0;
  logic [3:0]  div_bypass = '0;
  logic [4:0]  out_inv = '0;
  logic [4:0]  out_en = '0;
  logic [4:0]  bank_o;
  logic        ref_prev = 1'b0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tc = 0;
  bit done = 0;

  clkmx_route_top uut (
    .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .synth_clk_i(syn),
    .route_sel_i(route_sel), .div_a_i(div_a), .div_b_i(div_b),
    .div_pick_i(div_pick), .div_bypass_i(div_bypass),
    .out_inv_i(out_inv), .out_en_i(out_en), .bank_o(bank_o)
  );

  always #5 clk = ~clk;

  // sources change just after the edge; half periods 1,2,3,4 cycles
  always @(posedge clk) begin
    #1;
    tc++;
    ref_prev = ref_clk;
    ref_clk  = ((tc / 1) % 2) == 1;
    syn[0]   = ((tc / 2) % 2) == 1;
    syn[1]   = ((tc / 3) % 2) == 1;
    syn[2]   = ((tc / 4) % 2) == 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog R4 cycles=%0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_clear();
    route_sel = '0; div_a = '0; div_b = '0; div_pick = '0;
    div_bypass = '0; out_inv = '0; out_en = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // leaves the bench at the first negedge sample where bank b reads high after low
  task automatic wait_rise(input int b, output bit ok);
    int g = 0;
    ok = 1'b0;
    @(negedge clk);
    while (bank_o[b] && g < 5000) begin @(negedge clk); g++; end
    while (!bank_o[b] && g < 5000) begin @(negedge clk); g++; end
    ok = (g < 5000);
  endtask

  // starting at a rise sample: high cycles and cycles to the next rise
  task automatic measure_here(input int b, output int hi, output int per);
    int g = 0;
    hi = 0; per = 0;
    while (bank_o[b] && g < 5000) begin hi++; @(negedge clk); per++; g++; end
    while (!bank_o[b] && g < 5000) begin @(negedge clk); per++; g++; end
  endtask

  task automatic measure(input int b, output int hi, output int per);
    bit ok;
    hi = -1; per = -1;
    wait_rise(b, ok);
    if (!ok) return;
    wait_rise(b, ok);
    if (!ok) return;
    measure_here(b, hi, per);
  endtask

  // expected waveform restated from the requirements
  task automatic expect_wave(input vec_t v, output int hi, output int per,
                             output string tag);
    int sp = 2 * (int'(v.sel) + 1);
    int n  = v.pick ? int'(v.nb) : int'(v.na);
    if (v.bank == 3'd0) begin
      tag = "R1/R3"; per = sp; hi = sp / 2;
    end else if (v.byp) begin
      tag = "R1/R6"; per = sp; hi = sp / 2;
    end else if (n <= 1) begin
      tag = "R1/R5"; per = sp; hi = sp / 2;
    end else begin
      tag = v.pick ? "R1/R7/R4" : "R1/R4";
      per = n * sp;
      hi  = (n - n % 2) / 2 * sp;
    end
  endtask

  initial begin
    int hi, per, ehi, eper, bad, togg;
    string tag;
    bit ok;

    // R11: reset level equals inversion bits
    cfg_clear();
    out_en = 5'b11111; out_inv = 5'b10101;
    repeat (4) @(negedge clk);
    check("R11 reset level", int'(bank_o), 5'b10101);
    rst_n = 1'b1;

    // vector table
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      int b = int'(v.bank);
      cfg_clear();
      route_sel[b*2 +: 2] = v.sel;
      out_en[b] = 1'b1;
      if (b > 0) begin
        div_a[(b-1)*10 +: 10] = v.na;
        div_b[(b-1)*10 +: 10] = v.nb;
        div_pick[b-1]   = v.pick;
        div_bypass[b-1] = v.byp;
      end
      do_reset();
      expect_wave(v, ehi, eper, tag);
      measure(b, hi, per);
      check({tag, " period"}, per, eper);
      check({tag, " high"}, hi, ehi);
    end

    // R2: independent selects, all pass-through
    cfg_clear();
    route_sel = {2'd0, 2'd3, 2'd2, 2'd1, 2'd0};
    div_bypass = 4'b1111; out_en = 5'b11111;
    do_reset();
    for (int b = 0; b < 5; b++) begin
      measure(b, hi, per);
      check("R2 per-bank source period", per, (b == 4) ? 2 : 2 * (b + 1));
    end

    // R3: bank 1 equals reference one cycle late
    cfg_clear(); out_en = 5'b00001;
    do_reset();
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bank_o[0] != ref_prev) bad++;
    end
    check("R3 one-cycle latency mismatches", bad, 0);

    // R8: pick change just after period start waits for period end
    cfg_clear();
    out_en = 5'b00010;
    div_a[9:0] = 10'd4; div_b[9:0] = 10'd2;
    do_reset();
    wait_rise(1, ok);
    div_pick[0] = 1'b1;
    measure_here(1, hi, per);
    check("R8 old period kept", per, 8);
    check("R8 old high kept", hi, 4);
    measure_here(1, hi, per);
    check("R8 new period", per, 4);
    check("R8 new high", hi, 2);

    // R9: disabled outputs rest at inversion level
    cfg_clear();
    route_sel = 10'b00_11_00_01_00;
    div_a = {10'd3, 10'd3, 10'd3, 10'd3};
    out_en = 5'b00000; out_inv = 5'b10100;
    do_reset();
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bank_o != 5'b10100) bad++;
    end
    check("R9 disabled level mismatches", bad, 0);

    // R10: differential pair from opposite inversion
    cfg_clear();
    out_en = 5'b00011; out_inv = 5'b00010; div_bypass = 4'b0001;
    do_reset();
    bad = 0; togg = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bank_o[0] == bank_o[1]) bad++;
      if (bank_o[0]) togg++;
    end
    check("R10 pair equal samples", bad, 0);
    check("R10 pair toggles", (togg > 10 && togg < 30) ? 1 : 0, 1);

    done = 1;
    summary();
    $finish;
  end
endmodule